// File: doc/BRIEF.md
# Pipelined Grouped S-Box Byte Substitution

This block applies the AES forward byte substitution to a bus of state bytes. Every byte lane is handled on its own. The 256-entry substitution table is split into four groups of 64 entries. Each group holds four sub-tables of 16 entries. The two most significant bits of a byte pick the group through a 2-to-4 decoder. The next two bits pick a sub-table inside that group, and the low nibble picks the entry. These three lookups are spread over pipeline stages, so no single stage carries a flat 256-way multiplexer.

A parameter sets the lane count to 1, 2, 4, 8 or 16 bytes. Sixteen lanes substitute a whole AES state in one pass. The sub-table pick and the entry pick do not depend on each other's results. A second parameter can therefore fold them into one stage, which cuts the latency from four cycles to three.

The input is a single valid strobe qualifying the whole byte bus, and the output has the same shape. A new bus can enter on every clock, and the pipeline never stalls. The table contents are computed at elaboration from the finite-field definition of the S-box, so no list of constants is written out.

Top module: `sbgrp_subbytes`

## Requirements
- R1: For each of the 256 byte values, an output lane carries the AES forward S-box of its input byte, e.g. 0x00 gives 0x63, 0x53 gives 0xED, 0xFF gives 0x16.
- R2: Lane l takes its input from in_data bits [8l+7:8l] and drives out_data bits [8l+7:8l]; its result depends on no other lane's byte.
- R3: The first stage holds a one-hot group select in which bit g is set exactly when input bits [7:6] equal g; bytes that share bits [5:0] but differ in bits [7:6] give the S-box value of their own group.
- R4: With MERGE_MID = 0, out_vld and out_data show an input on the clock edge four edges after the edge that samples it, i.e. a latency of 4 cycles.
- R5: With MERGE_MID = 1, the sub-table and entry selection share one stage, and the latency is 3 cycles.
- R6: The pipeline accepts one input bus every cycle. A run of consecutive valid inputs produces the same number of consecutive valid outputs, each with its own correct data.
- R7: out_vld is high in a cycle exactly when in_vld was high the latency number of cycles earlier. Gaps in the input stream show up unchanged at the output.
- R8: rst is synchronous and active high. It clears every valid stage, so out_vld is low in the cycle after any reset edge and inputs already in flight are dropped. An in_vld seen on the same edge as rst is not accepted. Data registers are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Qualifies in_data for one cycle |
| in_data | input | LANES*8 | Input bytes, lane l at bits [8l+7:8l] |
| out_vld | output | 1 | Qualifies out_data |
| out_data | output | LANES*8 | Substituted bytes, lane l at bits [8l+7:8l] |

## Verification
The case that is hardest to reach from the ports is a reset that lands while the pipeline is full and in_vld is still high. Both the dropped in-flight bytes and the refused new input have to vanish, and nothing else may be lost. The stimulus builds a dense valid stream, then holds rst for two cycles without lowering in_vld, and then resumes the stream. The expected-valid history is cleared over exactly the window the reset covers. A rotating sweep gives every lane all 256 values. A group sweep holds bits [5:0] fixed while stepping bits [7:6]. Two instances, one merged and one unmerged, check both latencies on the same stimulus.

// File: rtl/sbgrp_pkg.sv
package sbgrp_pkg;

  localparam int BYTE_W  = 8;
  localparam int GSEL_W  = 2;
  localparam int SSEL_W  = 2;
  localparam int ESEL_W  = 4;
  localparam int GROUPS  = 1 << GSEL_W;
  localparam int SUBS    = 1 << SSEL_W;
  localparam int ENTRIES = 1 << ESEL_W;

  typedef logic [ENTRIES-1:0][BYTE_W-1:0] subtbl_t;
  typedef subtbl_t [SUBS-1:0]             grptbl_t;
  typedef grptbl_t [GROUPS-1:0]           sbox_tbl_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    logic [7:0] ex;
    res  = 8'h01;
    base = a;
    ex   = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_affine(input logic [7:0] v);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    return sbox_affine(gf_inv(a));
  endfunction

  function automatic logic [GROUPS-1:0] dec2to4(input logic [GSEL_W-1:0] sel);
    logic [GROUPS-1:0] oh;
    oh = '0;
    for (int g = 0; g < GROUPS; g++) oh[g] = (sel == GSEL_W'(g));
    return oh;
  endfunction

endpackage

// File: rtl/sbgrp_table.sv
module sbgrp_table
  import sbgrp_pkg::*;
(
  output sbox_tbl_t tbl
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar s = 0; s < SUBS; s++) begin : g_sub
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [7:0] IDX = 8'((g * SUBS + s) * ENTRIES + e);
        assign tbl[g][s][e] = sbox_fwd(IDX);
      end
    end
  end

endmodule

// File: rtl/sbgrp_vpipe.sv
module sbgrp_vpipe #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_in,
  output logic [DEPTH-1:0] vld_stage
);

  always_ff @(posedge clk) begin
    if (rst) vld_stage[0] <= 1'b0;
    else     vld_stage[0] <= vld_in;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst) vld_stage[k] <= 1'b0;
      else     vld_stage[k] <= vld_stage[k-1];
    end
  end

endmodule

// File: rtl/sbgrp_lane.sv
module sbgrp_lane
  import sbgrp_pkg::*;
#(
  parameter bit MERGE_MID = 1'b0
) (
  input  logic              clk,
  input  logic [BYTE_W-1:0] byte_in,
  input  sbox_tbl_t         tbl,
  output logic [GROUPS-1:0] grp_sel_q,
  output logic [BYTE_W-1:0] byte_out
);

  logic [SSEL_W-1:0] mid_q;
  logic [ESEL_W-1:0] lo_q;
  grptbl_t           grp_row;
  subtbl_t           sub_row;
  logic [BYTE_W-1:0] pick;
  logic [BYTE_W-1:0] pick_q;

  // stage 1: decoded group plus remaining index bits
  always_ff @(posedge clk) begin
    grp_sel_q <= dec2to4(byte_in[BYTE_W-1 -: GSEL_W]);
    mid_q     <= byte_in[ESEL_W +: SSEL_W];
    lo_q      <= byte_in[ESEL_W-1:0];
  end

  always_comb begin
    grp_row = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp_sel_q[g]) grp_row = grp_row | tbl[g];
    end
    sub_row = grp_row[mid_q];
  end

  if (MERGE_MID) begin : g_merged
    assign pick = sub_row[lo_q];
  end else begin : g_split
    subtbl_t           row_q;
    logic [ESEL_W-1:0] lo2_q;
    always_ff @(posedge clk) begin
      row_q <= sub_row;
      lo2_q <= lo_q;
    end
    assign pick = row_q[lo2_q];
  end

  always_ff @(posedge clk) begin
    pick_q   <= pick;
    byte_out <= pick_q;
  end

endmodule

// File: rtl/sbgrp_subbytes.sv
module sbgrp_subbytes
  import sbgrp_pkg::*;
#(
  parameter int LANES     = 16,
  parameter bit MERGE_MID = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [LANES*8-1:0]    in_data,
  output logic                  out_vld,
  output logic [LANES*8-1:0]    out_data
);

  localparam int LAT = MERGE_MID ? 3 : 4;

  if (!(LANES == 1 || LANES == 2 || LANES == 4 || LANES == 8 || LANES == 16)) begin : g_bad
    $error("sbgrp_subbytes: LANES must be 1, 2, 4, 8 or 16");
  end

  sbox_tbl_t                tbl;
  logic [LAT-1:0]           vld_stage;
  logic                     s1_vld;
  logic [LANES*GROUPS-1:0]  s1_grp_all;

  sbgrp_table u_tbl (.tbl(tbl));

  sbgrp_vpipe #(.DEPTH(LAT)) u_vpipe (
    .clk      (clk),
    .rst      (rst),
    .vld_in   (in_vld),
    .vld_stage(vld_stage)
  );

  assign s1_vld  = vld_stage[0];
  assign out_vld = vld_stage[LAT-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sbgrp_lane #(.MERGE_MID(MERGE_MID)) u_lane (
      .clk      (clk),
      .byte_in  (in_data[l*BYTE_W +: BYTE_W]),
      .tbl      (tbl),
      .grp_sel_q(s1_grp_all[l*GROUPS +: GROUPS]),
      .byte_out (out_data[l*BYTE_W +: BYTE_W])
    );
  end

endmodule

// File: rtl/sbgrp_chk.sv
module sbgrp_chk
  import sbgrp_pkg::*;
#(
  parameter int LANES = 16,
  parameter int LAT   = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_vld,
  input logic [LANES*8-1:0]       in_data,
  input logic                     out_vld,
  input logic [LANES*8-1:0]       out_data,
  input logic                     s1_vld,
  input logic [LANES*GROUPS-1:0]  s1_grp
);

  logic [3:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= 4'd0;
    else if (since_rst < 4'(LAT)) since_rst <= since_rst + 4'd1;
  end

  assign warm = (since_rst >= 4'(LAT));

  // R8
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_vld && !s1_vld));

  // R7 (and R4/R5 through LAT)
  a_r7_valid_follow: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_vld == $past(in_vld, LAT)));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R1
    a_r1_sbox_value: assert property (@(posedge clk) disable iff (rst)
      (warm && out_vld) |->
        (out_data[l*8 +: 8] == sbox_fwd($past(in_data[l*8 +: 8], LAT))));

    // R3
    a_r3_group_onehot: assert property (@(posedge clk) disable iff (rst)
      s1_vld |-> ($countones(s1_grp[l*GROUPS +: GROUPS]) == 1));

    // R3
    a_r3_group_match: assert property (@(posedge clk) disable iff (rst)
      s1_vld |->
        (s1_grp[l*GROUPS +: GROUPS] == (GROUPS'(1) << $past(in_data[l*8+6 +: 2]))));
  end

endmodule

bind sbgrp_subbytes sbgrp_chk #(.LANES(LANES), .LAT(LAT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_data (in_data),
  .out_vld (out_vld),
  .out_data(out_data),
  .s1_vld  (s1_vld),
  .s1_grp  (s1_grp_all)
);

// File: tb/sim_sbgrp_subbytes.sv
module sim_sbgrp_subbytes;

  localparam int MAXC = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_vld0, out_vld1;
  logic [127:0] out_data0;
  logic [31:0]  out_data1;

  always #5 clk = ~clk;

  sbgrp_subbytes #(.LANES(16), .MERGE_MID(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld0), .out_data(out_data0)
  );

  sbgrp_subbytes #(.LANES(4), .MERGE_MID(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data[31:0]),
    .out_vld(out_vld1), .out_data(out_data1)
  );

  logic [7:0]   ref_tbl [256];
  bit           hv [MAXC];
  logic [127:0] hd [MAXC];
  int           cyc = 0;
  int           errs = 0;
  int           checks = 0;
  bit           done = 1'b0;
  string        tag_v = "R8";
  string        tag_d = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // reference built from shift-and-add multiply, exhaustive inverse search
  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] b_inv(input logic [7:0] x);
    if (x == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++) if (b_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_aff(input logic [7:0] x);
    logic [7:0] y;
    logic [7:0] c;
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      y[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ c[i];
    return y;
  endfunction

  task automatic chk_v(input logic got, input logic exp, input string rq);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s/%s valid at cycle %0d: got %b expected %b", rq, tag_v, cyc, got, exp);
    end
  endtask

  task automatic chk_b(input logic [7:0] got, input logic [7:0] exp, input string rq, input int lane);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s/%s lane %0d cycle %0d: got %02h expected %02h", rq, tag_d, lane, cyc, got, exp);
    end
  endtask

  task automatic compare(input int m);
    logic e0, e1;
    e0 = (m >= 4) ? hv[m-4] : 1'b0;
    e1 = (m >= 3) ? hv[m-3] : 1'b0;
    chk_v(out_vld0, e0, "R4");
    chk_v(out_vld1, e1, "R5");
    if (e0) for (int l = 0; l < 16; l++)
      chk_b(out_data0[l*8 +: 8], ref_tbl[hd[m-4][l*8 +: 8]], "R4", l);
    if (e1) for (int l = 0; l < 4; l++)
      chk_b(out_data1[l*8 +: 8], ref_tbl[hd[m-3][l*8 +: 8]], "R5", l);
  endtask

  task automatic step(input logic v, input logic [127:0] d, input logic r);
    int m;
    @(negedge clk);
    m = cyc;
    compare(m);
    rst     = r;
    in_vld  = v;
    in_data = d;
    hv[m]   = v && !r;
    hd[m]   = d;
    if (r) for (int k = 1; k <= 3; k++) if (m - k >= 0) hv[m-k] = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) ref_tbl[i] = b_aff(b_inv(8'(i)));
    for (int i = 0; i < MAXC; i++) begin hv[i] = 1'b0; hd[i] = '0; end

    // R8: reset dominates a high in_vld; outputs stay invalid
    tag_v = "R8"; tag_d = "R8";
    for (int i = 0; i < 6; i++) step(1'b1, rnd128(), 1'b1);

    // R1 R6: every lane sees all 256 values, back to back
    tag_v = "R6"; tag_d = "R1";
    for (int i = 0; i < 256; i++) begin
      for (int l = 0; l < 16; l++) d[l*8 +: 8] = 8'(i + 16 * l);
      step(1'b1, d, 1'b0);
    end

    // R3: fixed low six bits, step through the four groups
    tag_v = "R3"; tag_d = "R3";
    for (int k = 0; k < 12; k++) begin
      logic [5:0] low6;
      low6 = 6'($urandom);
      for (int g = 0; g < 4; g++) begin
        for (int l = 0; l < 16; l++) d[l*8 +: 8] = {2'(g), low6 ^ 6'(l)};
        step(1'b1, d, 1'b0);
      end
    end

    // R1 corner values in all lanes: 00->63, 53->ED, FF->16
    tag_d = "R1";
    step(1'b1, {16{8'h00}}, 1'b0);
    step(1'b1, {16{8'h53}}, 1'b0);
    step(1'b1, {16{8'hff}}, 1'b0);

    // R2 R7: random data with gaps in the valid stream
    tag_v = "R7"; tag_d = "R2";
    for (int i = 0; i < 800; i++) step(($urandom % 4) != 0, rnd128(), 1'b0);

    // R8: reset with a full pipeline and in_vld kept high
    tag_v = "R8"; tag_d = "R8";
    for (int i = 0; i < 10; i++) step(1'b1, rnd128(), 1'b0);
    step(1'b1, rnd128(), 1'b1);
    step(1'b1, rnd128(), 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, rnd128(), 1'b0);

    // drain
    tag_v = "R7"; tag_d = "R2";
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule